// File: doc/BRIEF.md
# PCIe Slot Hot-Plug Controller

This block holds the hot-plug state of one downstream port: the 16-bit slot control and slot status registers and the link status register, all reached through a byte-granular configuration write port and a dword read port. A management agent reports device insertion, asks for removal (optionally in a fast mode), and is told when a request is refused because a previous power transition has not finished. The block raises either a level interrupt or a single-cycle message request whenever its combined notification state flips.

Guest software enables events and clears them by writing ones. A clear that names an event which was never pending is taken as a stale write and undone, so events that arrive between a read and a write-back are not lost. Turning slot power off together with an "off" power indicator while a device is present removes the device, which the block reports with a pulse.

The capability sits at parameter `CAP_OFS`; slot control is at `CAP_OFS+0x18`, slot status at `CAP_OFS+0x1A`, link status at `CAP_OFS+0x12`. With the defaults the slot dword is dword index 0x16 (`{status, control}`) and the link dword is index 0x14 (`{link status, 16'h0}`).

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, slot control reads 0x0100 (indicator on, power on, all interrupt enables 0), slot status reads 0x0040 (only presence-detect-state), link status reads 0x2000 (only link-active), and the level interrupt and all pulses are 0.
- R2: The event bits are status bit 0 (attention button), bit 3 (presence changed) and bit 4 (command completed); writing 1 clears an event, writing 0 leaves it. Presence-detect-state (status bit 6) and every link status bit cannot be changed by the write port.
- R3: If a status write carries a 1 in an event bit that was 0 before the write, no event bit changes in that write.
- R4: Notification is pending when control bit 5 is 1 and status AND control AND 0x0019 is non-zero. At each notify check, only a change of that state signals: with `msi_en` high, `msi_req` pulses for one cycle; otherwise, when `int_pin` is non-zero, `intx_level` takes the new state. `intx_level` never changes while `msi_en` is high.
- R5: A status write re-evaluates the pending state without any message pulse, and drops `intx_level` when nothing is pending (with `msi_en` low and `int_pin` non-zero).
- R6: Every slot control write is followed by a notify check on the written state and, one cycle later, by setting command-completed (status bit 4) and a second notify check.
- R7: A slot control write removes the device when presence-detect-state is 1, the new value has control bit 10 set and bits 9:8 equal to 2'b11, and the old value lacked either of those. Removal clears presence-detect-state and link-active (link bit 13), sets presence-changed, and pulses `remove_pulse`.
- R8: A plug with `plug_func` 0 sets status bits 6, 3 and 0, sets link status bits to speed 1 (bits 3:0), width 1 (bits 9:4) and link-active, then runs a notify check. A plug for any other function has no effect.
- R9: An unplug request while control bits 9:8 read 2'b10 (blinking) changes nothing and pulses `req_rejected`.
- R10: An accepted unplug request clears link-active and sets presence-changed only when `fast_unplug` is high; if power is already off (bit 10) and the indicator is already 2'b11 it stops there without a notify check, otherwise it also sets attention-button and runs a notify check.
- R11: Write byte i of `wr_data` (bits 8i+7:8i) lands at offset `wr_off`+i; a write with `wr_len` of 0 or above 4, or one ending past `CFG_BYTES`, is ignored.
- R12: `rd_data` returns, one cycle after `rd_dw` is presented, the slot dword, the link dword, or 0 for any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Config write strobe |
| wr_off | input | ADDR_W | Byte offset of first written byte |
| wr_len | input | 3 | Number of bytes written |
| wr_data | input | 32 | Write bytes, first byte in bits 7:0 |
| rd_dw | input | ADDR_W-2 | Dword index to read |
| rd_data | output | 32 | Registered read data |
| msi_en | input | 1 | Message interrupts enabled |
| int_pin | input | 8 | Interrupt pin register value |
| plug | input | 1 | Device inserted (pulse) |
| plug_func | input | FUNC_W | Function number of inserted device |
| unplug_req | input | 1 | Removal requested (pulse) |
| fast_unplug | input | 1 | Fast removal mode |
| intx_level | output | 1 | Level interrupt |
| msi_req | output | 1 | One-cycle message request |
| remove_pulse | output | 1 | Device removed |
| req_rejected | output | 1 | Unplug request refused |

## Verification
The bench aims at the stale-clear rollback, where a design that lets the write through silently loses an event the guest never saw, and at the split command-completed check, where a design that sets the bit in the same cycle as the control write either misses the interrupt that only command-completed should raise or merges two transitions into one. It replays the power-off write with the port already off, which a level-triggered removal would turn into a second removal, and a status write in message mode, which must not emit a message. It also drives the fast-removal request with power already off, where a design that skipped the early stop would set attention-button, and a misaligned two-byte write that a wrong byte lane mapping would place into the wrong control byte.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned CTL_REL     = 'h18;
  localparam int unsigned STS_REL     = 'h1A;
  localparam int unsigned LINK_DW_REL = 'h10;

  localparam int unsigned C_HPI_EN  = 5;
  localparam int unsigned C_PWR_OFF = 10;
  localparam int unsigned S_ABP     = 0;
  localparam int unsigned S_PDC     = 3;
  localparam int unsigned S_CC      = 4;
  localparam int unsigned S_PDS     = 6;
  localparam int unsigned L_ACTIVE  = 13;

  localparam logic [1:0]  IND_BLINK = 2'b10;
  localparam logic [1:0]  IND_OFF   = 2'b11;

  localparam logic [15:0] EVT_MASK  = 16'h0019;
  localparam logic [15:0] CTL_WMASK = 16'h07FF;
  localparam logic [15:0] CTL_RST   = 16'h0100;
  localparam logic [15:0] STS_RST   = 16'h0040;
  localparam logic [15:0] LINK_RST  = 16'h2000;
  localparam logic [15:0] LINK_UP   = 16'h2011;

  function automatic logic is_off(input logic [15:0] ctl);
    return ctl[C_PWR_OFF] && (ctl[9:8] == IND_OFF);
  endfunction
endpackage

// File: rtl/hp_wr_decode.sv
module hp_wr_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CFG_BYTES = 4096,
  parameter int unsigned REG_OFS   = 'h58,
  parameter int unsigned REG_BYTES = 2
) (
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_off,
  input  logic [2:0]             wr_len,
  input  logic [31:0]            wr_data,
  output logic                   hit,
  output logic [REG_BYTES-1:0]   be,
  output logic [8*REG_BYTES-1:0] data
);
  logic [ADDR_W:0] start_pos, end_pos;
  logic            legal;

  assign start_pos = {1'b0, wr_off};
  assign end_pos   = start_pos + (ADDR_W+1)'(wr_len);
  assign legal     = wr_en && (wr_len != 3'd0) && (wr_len <= 3'd4) &&
                     (end_pos <= (ADDR_W+1)'(CFG_BYTES));

  for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
    localparam int unsigned POS = REG_OFS + b;
    logic [ADDR_W:0] rel;
    logic [1:0]      lane;
    assign rel   = (ADDR_W+1)'(POS) - start_pos;
    assign lane  = rel[1:0];
    assign be[b] = legal && ((ADDR_W+1)'(POS) >= start_pos) &&
                   ((ADDR_W+1)'(POS) < end_pos);
    assign data[8*b +: 8] = wr_data[{lane, 3'b000} +: 8];
  end

  assign hit = |be;
endmodule

// File: rtl/hp_notify.sv
module hp_notify
  import hp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        chk_stb,
  input  logic        clr_stb,
  input  logic [15:0] slot_ctl,
  input  logic [15:0] slot_sts,
  input  logic        msi_en,
  input  logic [7:0]  int_pin,
  output logic        intx_level,
  output logic        msi_req
);
  logic pending, prev_q;

  assign pending = slot_ctl[C_HPI_EN] && |(slot_sts & slot_ctl & EVT_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= 1'b0;
      intx_level <= 1'b0;
      msi_req    <= 1'b0;
    end else begin
      msi_req <= 1'b0;
      if (clr_stb) begin
        prev_q <= pending;
        if (!msi_en && (int_pin != 8'h00) && !pending) intx_level <= 1'b0;
      end else if (chk_stb && (pending != prev_q)) begin
        prev_q <= pending;
        if (msi_en) msi_req <= 1'b1;
        else if (int_pin != 8'h00) intx_level <= pending;
      end
    end
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CFG_BYTES = 4096,
  parameter int unsigned CAP_OFS   = 'h40,
  parameter int unsigned FUNC_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_off,
  input  logic [2:0]        wr_len,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-3:0] rd_dw,
  output logic [31:0]       rd_data,
  input  logic              msi_en,
  input  logic [7:0]        int_pin,
  input  logic              plug,
  input  logic [FUNC_W-1:0] plug_func,
  input  logic              unplug_req,
  input  logic              fast_unplug,
  output logic              intx_level,
  output logic              msi_req,
  output logic              remove_pulse,
  output logic              req_rejected
);
  localparam int unsigned CTL_OFS = CAP_OFS + CTL_REL;
  localparam int unsigned STS_OFS = CAP_OFS + STS_REL;
  localparam int unsigned SLOT_DW = CTL_OFS / 4;
  localparam int unsigned LINK_DW = (CAP_OFS + LINK_DW_REL) / 4;

  logic [15:0] ctl_q, sts_q, link_q, ctl_d, sts_d, link_d;
  logic        stage_q, chk_q, clr_q;
  logic        ctl_hit, sts_hit;
  logic [1:0]  ctl_be, sts_be;
  logic [15:0] ctl_wd, sts_wd;

  hp_wr_decode #(.ADDR_W(ADDR_W), .CFG_BYTES(CFG_BYTES), .REG_OFS(CTL_OFS), .REG_BYTES(2))
    u_ctl_dec (.wr_en(wr_en), .wr_off(wr_off), .wr_len(wr_len), .wr_data(wr_data),
               .hit(ctl_hit), .be(ctl_be), .data(ctl_wd));
  hp_wr_decode #(.ADDR_W(ADDR_W), .CFG_BYTES(CFG_BYTES), .REG_OFS(STS_OFS), .REG_BYTES(2))
    u_sts_dec (.wr_en(wr_en), .wr_off(wr_off), .wr_len(wr_len), .wr_data(wr_data),
               .hit(sts_hit), .be(sts_be), .data(sts_wd));

  logic [15:0] ctl_merge, ctl_new, sts_wv, sts_after;
  logic        stale_clr, remove, mgmt_ok, plug_go, unp_go, unp_rej, unp_quiet;

  assign ctl_merge = {ctl_be[1] ? ctl_wd[15:8] : ctl_q[15:8],
                      ctl_be[0] ? ctl_wd[7:0]  : ctl_q[7:0]};
  assign ctl_new   = (ctl_merge & CTL_WMASK) | (ctl_q & ~CTL_WMASK);
  assign sts_wv    = {sts_be[1] ? sts_wd[15:8] : 8'h00,
                      sts_be[0] ? sts_wd[7:0]  : 8'h00};
  assign stale_clr = sts_hit && |(sts_wv & ~sts_q & EVT_MASK);
  assign sts_after = (sts_hit && !stale_clr) ? (sts_q & ~(sts_wv & EVT_MASK)) : sts_q;
  assign remove    = ctl_hit && sts_q[S_PDS] && is_off(ctl_new) && !is_off(ctl_q);
  assign mgmt_ok   = !(ctl_hit || sts_hit);
  assign plug_go   = plug && mgmt_ok && (plug_func == '0);
  assign unp_rej   = unplug_req && mgmt_ok && (ctl_q[9:8] == IND_BLINK);
  assign unp_go    = unplug_req && mgmt_ok && (ctl_q[9:8] != IND_BLINK);
  assign unp_quiet = is_off(ctl_q);

  always_comb begin
    ctl_d  = ctl_hit ? ctl_new : ctl_q;
    sts_d  = sts_after;
    link_d = link_q;
    if (remove) begin
      sts_d[S_PDS]     = 1'b0;
      sts_d[S_PDC]     = 1'b1;
      link_d[L_ACTIVE] = 1'b0;
    end
    if (stage_q) sts_d[S_CC] = 1'b1;
    if (plug_go) begin
      sts_d[S_PDS] = 1'b1;
      sts_d[S_PDC] = 1'b1;
      sts_d[S_ABP] = 1'b1;
      link_d       = link_d | LINK_UP;
    end
    if (unp_go) begin
      link_d[L_ACTIVE] = 1'b0;
      if (fast_unplug) sts_d[S_PDC] = 1'b1;
      if (!unp_quiet)  sts_d[S_ABP] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q        <= CTL_RST;
      sts_q        <= STS_RST;
      link_q       <= LINK_RST;
      stage_q      <= 1'b0;
      chk_q        <= 1'b0;
      clr_q        <= 1'b0;
      remove_pulse <= 1'b0;
      req_rejected <= 1'b0;
      rd_data      <= 32'h0;
    end else begin
      ctl_q        <= ctl_d;
      sts_q        <= sts_d;
      link_q       <= link_d;
      stage_q      <= ctl_hit;
      chk_q        <= ctl_hit || stage_q || plug_go || (unp_go && !unp_quiet);
      clr_q        <= sts_hit;
      remove_pulse <= remove;
      req_rejected <= unp_rej;
      if (rd_dw == (ADDR_W-2)'(SLOT_DW))      rd_data <= {sts_q, ctl_q};
      else if (rd_dw == (ADDR_W-2)'(LINK_DW)) rd_data <= {link_q, 16'h0000};
      else                                    rd_data <= 32'h0;
    end
  end

  hp_notify u_notify (
    .clk(clk), .rst(rst), .chk_stb(chk_q), .clr_stb(clr_q),
    .slot_ctl(ctl_q), .slot_sts(sts_q), .msi_en(msi_en), .int_pin(int_pin),
    .intx_level(intx_level), .msi_req(msi_req)
  );
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        msi_en,
  input logic        msi_req,
  input logic        intx_level,
  input logic        remove_pulse,
  input logic        req_rejected,
  input logic        plug,
  input logic [15:0] ctl_q,
  input logic [15:0] sts_q,
  input logic [15:0] link_q
);
  // R4
  msi_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    msi_req |-> $past(msi_en));
  // R4
  intx_hold_in_msi_chk: assert property (@(posedge clk) disable iff (rst)
    msi_en |=> $stable(intx_level));
  // R7
  removal_effect_chk: assert property (@(posedge clk) disable iff (rst)
    remove_pulse |-> (!sts_q[6] && !link_q[13] && sts_q[3]));
  // R9
  reject_on_blink_chk: assert property (@(posedge clk) disable iff (rst)
    req_rejected |-> ($past(ctl_q[9:8]) == 2'b10));
  // R2
  pds_source_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sts_q[6]) |-> ($past(plug) || remove_pulse));
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .msi_en(msi_en), .msi_req(msi_req),
  .intx_level(intx_level), .remove_pulse(remove_pulse),
  .req_rejected(req_rejected), .plug(plug),
  .ctl_q(ctl_q), .sts_q(sts_q), .link_q(link_q)
);

// File: tb/tb_hp_slot_ctrl.sv
module tb_hp_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_off = '0;
  logic [2:0]  wr_len = '0;
  logic [31:0] wr_data = '0;
  logic [9:0]  rd_dw = '0;
  logic [31:0] rd_data;
  logic        msi_en = 1'b0;
  logic [7:0]  int_pin = 8'h01;
  logic        plug = 1'b0;
  logic [2:0]  plug_func = '0;
  logic        unplug_req = 1'b0;
  logic        fast_unplug = 1'b0;
  logic        intx_level, msi_req, remove_pulse, req_rejected;

  always #10 clk = ~clk;

  hp_slot_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_len(wr_len),
    .wr_data(wr_data), .rd_dw(rd_dw), .rd_data(rd_data), .msi_en(msi_en),
    .int_pin(int_pin), .plug(plug), .plug_func(plug_func),
    .unplug_req(unplug_req), .fast_unplug(fast_unplug),
    .intx_level(intx_level), .msi_req(msi_req),
    .remove_pulse(remove_pulse), .req_rejected(req_rejected)
  );

  localparam logic [9:0] SLOT_DW = 10'h16;
  localparam logic [9:0] LINK_DW = 10'h14;

  typedef struct packed {
    logic [11:0] off;
    logic [2:0]  len;
    logic [31:0] data;
    logic [31:0] exp_slot;
    logic        exp_intx;
    logic [3:0]  req;
  } vec_t;

  // R6 R3 R5 R11 R2 exercised by the rows below
  localparam vec_t VEC [0:9] = '{
    '{12'h058, 3'd2, 32'h0000_0129, 32'h0059_0129, 1'b1, 4'd4},
    '{12'h05A, 3'd2, 32'h0000_0010, 32'h0049_0129, 1'b1, 4'd5},
    '{12'h05A, 3'd2, 32'h0000_0011, 32'h0049_0129, 1'b1, 4'd3},
    '{12'h05A, 3'd2, 32'h0000_0009, 32'h0040_0129, 1'b0, 4'd5},
    '{12'h058, 3'd5, 32'h0000_FFFF, 32'h0040_0129, 1'b0, 4'd11},
    '{12'h057, 3'd2, 32'h0000_2000, 32'h0050_0120, 1'b0, 4'd11},
    '{12'h05A, 3'd1, 32'h0000_0010, 32'h0040_0120, 1'b0, 4'd2},
    '{12'h058, 3'd2, 32'h0000_0130, 32'h0050_0130, 1'b1, 4'd6},
    '{12'h05A, 3'd2, 32'h0000_0010, 32'h0040_0130, 1'b0, 4'd5},
    '{12'h05A, 3'd2, 32'h0000_0040, 32'h0040_0130, 1'b0, 4'd2}
  };

  int checks = 0;
  int errors = 0;
  int msi_cnt = 0, rm_cnt = 0, rej_cnt = 0;
  logic [31:0] rv;

  always @(negedge clk) begin
    if (!rst) begin
      if (msi_req)      msi_cnt++;
      if (remove_pulse) rm_cnt++;
      if (req_rejected) rej_cnt++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic cfg_wr(input logic [11:0] off, input logic [2:0] len, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_len = len; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_rd(input logic [9:0] dw, output logic [31:0] v);
    @(negedge clk);
    rd_dw = dw;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic do_plug(input logic [2:0] f);
    @(negedge clk);
    plug = 1'b1; plug_func = f;
    @(negedge clk);
    plug = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_unplug(input logic fast);
    @(negedge clk);
    unplug_req = 1'b1; fast_unplug = fast;
    @(negedge clk);
    unplug_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cfg_rd(SLOT_DW, rv); check("R1 slot", rv, 32'h0040_0100);
    cfg_rd(LINK_DW, rv); check("R1 link", rv, 32'h2000_0000);
    check("R1 intx", {31'h0, intx_level}, 32'h0);
    // R8 plug for a non-zero function does nothing
    do_plug(3'd1);
    cfg_rd(SLOT_DW, rv); check("R8 func1 slot", rv, 32'h0040_0100);
    cfg_rd(LINK_DW, rv); check("R8 func1 link", rv, 32'h2000_0000);
    // R8 plug for function 0
    do_plug(3'd0);
    cfg_rd(SLOT_DW, rv); check("R8 plug slot", rv, 32'h0049_0100);
    cfg_rd(LINK_DW, rv); check("R8 plug link", rv, 32'h2011_0000);

    for (int i = 0; i < 10; i++) begin
      cfg_wr(VEC[i].off, VEC[i].len, VEC[i].data);
      cfg_rd(SLOT_DW, rv);
      check($sformatf("R%0d vector %0d slot", VEC[i].req, i), rv, VEC[i].exp_slot);
      check($sformatf("R4 vector %0d intx", i), {31'h0, intx_level}, {31'h0, VEC[i].exp_intx});
    end

    // R4 message mode: command-completed raises one message
    msi_en = 1'b1;
    cfg_wr(12'h058, 3'd2, 32'h0130);
    check("R4 msi count", msi_cnt, 1);
    check("R4 intx quiet in msi", {31'h0, intx_level}, 32'h0);
    // R5 status write sends no message
    cfg_wr(12'h05A, 3'd2, 32'h0010);
    check("R5 no msi on clear", msi_cnt, 1);
    // R7 power off with indicator off removes the device
    cfg_wr(12'h058, 3'd2, 32'h0730);
    check("R7 remove count", rm_cnt, 1);
    cfg_rd(SLOT_DW, rv); check("R7 slot after removal", rv, 32'h0018_0730);
    cfg_rd(LINK_DW, rv); check("R7 link after removal", rv, 32'h0011_0000);
    check("R6 msi after removal write", msi_cnt, 2);
    // R8 replug, then R7 repeat of the off write does not remove again
    do_plug(3'd0);
    cfg_rd(LINK_DW, rv); check("R8 replug link", rv, 32'h2011_0000);
    cfg_wr(12'h058, 3'd2, 32'h0730);
    check("R7 no second removal", rm_cnt, 1);
    cfg_rd(SLOT_DW, rv); check("R7 slot kept", rv, 32'h0059_0730);
    // R9 blinking indicator refuses the request
    cfg_wr(12'h058, 3'd2, 32'h0230);
    do_unplug(1'b0);
    check("R9 rejected", rej_cnt, 1);
    cfg_rd(LINK_DW, rv); check("R9 link unchanged", rv, 32'h2011_0000);
    // R10 normal unplug request
    cfg_wr(12'h058, 3'd2, 32'h0100);
    check("R4 msi on enable drop", msi_cnt, 3);
    cfg_wr(12'h05A, 3'd2, 32'h0019);
    do_unplug(1'b0);
    cfg_rd(SLOT_DW, rv); check("R10 slot normal", rv, 32'h0041_0100);
    cfg_rd(LINK_DW, rv); check("R10 link normal", rv, 32'h0011_0000);
    // R10 fast request with power and indicator already off
    cfg_wr(12'h058, 3'd2, 32'h0700);
    check("R7 remove on 0x0700", rm_cnt, 2);
    cfg_wr(12'h05A, 3'd2, 32'h0019);
    do_unplug(1'b1);
    cfg_rd(SLOT_DW, rv); check("R10 fast quiet slot", rv, 32'h0008_0700);
    check("R9 no reject when accepted", rej_cnt, 1);
    // R12 unmapped dword
    cfg_rd(10'h000, rv); check("R12 unmapped", rv, 32'h0);
    finish_run();
  end
endmodule